// File: doc/BRIEF.md
# Prefix Active-Part Extractor

This block turns a routing prefix into a compact triplet: the length of its leading run, the bits of its active part, and the length of its trailing run. The prefix arrives left-aligned in a fixed-width field with a separate length. Position 0 is the most significant bit of the field. Bits at positions at or beyond the length are don't-care.

The leading run ends at the first position whose bit differs from the bit at position 0. The trailing run starts at the last position whose bit differs from the final bit of the prefix. Which bit value each scan looks for depends on the pair (first bit, last bit), so there are four cases. Both boundary bits belong to the runs, not to the active part. The active part is emitted left-aligned with its length.

Each result also carries a conflict flag. The flag is raised when the result's active part is non-empty and equal to the active part of the prefix accepted just before it. A table builder can use this flag to spot prefixes that would collide.

Both sides are valid/ready streams. An input is taken on a cycle where `in_valid` and `in_ready` are both high. A result is delivered on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` stays low. The pipeline has no skid storage, so back-pressure reaches the input in the same cycle. Without back-pressure, one prefix is accepted every cycle and its result appears two clock edges later.

Top module: `prefix_ap_extractor`

## Requirements
- R1: `out_x_len` is i+1, where i is the smallest position (i ≥ 1, i < length) whose bit differs from the bit at position 0. That means the first 1 when the first bit is 0, and the first 0 when the first bit is 1.
- R2: `out_z_len` is length−j, where j is the largest position (j < length−1) whose bit differs from the last prefix bit. That means the last 1 when the last bit is 0, and the last 0 when the last bit is 1.
- R3: `out_ap_len` is j−i−1, and `out_ap` holds the bits at positions i+1..j−1. The bit at position i+1 sits at bit W−1 of `out_ap`, and every bit below the active part is 0. The two boundary bits are excluded.
- R4: Bits of `in_prefix` at positions at or beyond `in_len` have no effect on any result. An `in_len` above W is treated as W.
- R5: If either boundary does not exist, or if j ≤ i+1, the result is empty. This covers a single repeated value and any length under 3. An empty result has `out_x_len`, `out_z_len`, `out_ap_len` and `out_ap` all equal to 0.
- R6: `out_conflict` is 1 exactly when the result's active part is non-empty and equal in bits and length to the active part of the previously accepted prefix.
- R7: An accepted input shows its result on `out_valid` two clock edges later when no stall occurs. Back-to-back inputs are accepted on consecutive cycles.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output stays stable and `in_ready` is 0.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1. The first result after reset has `out_conflict` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input prefix present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_prefix | input | W (32) | Prefix bits, position 0 at the MSB |
| in_len | input | clog2(W+1) (6) | Prefix length in bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_x_len | output | clog2(W+1) (6) | Leading run length, including its boundary bit |
| out_z_len | output | clog2(W+1) (6) | Trailing run length, including its boundary bit |
| out_ap | output | W (32) | Active part, left-aligned |
| out_ap_len | output | clog2(W+1) (6) | Active part length |
| out_conflict | output | 1 | Active part equals the previous one |

## Verification
The bench builds the block with W at its default of 32 and the length port 6 bits wide. This lets it drive full-width prefixes whose boundaries sit at positions 1 and 30. It also lets it drive lengths above 32, to exercise clamping, and lengths of 0 and 2. The tail of the field can be filled with arbitrary bits to show that they are ignored. The vector table covers all four end-bit cases and the paired conflict examples. Directed runs cover back-to-back streaming, a held stall and reset clearing the conflict history.

// File: rtl/prefix_ap_pkg.sv
package prefix_ap_pkg;
  // Pair of (first bit, last bit) selecting which bit value each scan hunts for.
  typedef enum logic [1:0] {
    ENDS_00 = 2'b00,
    ENDS_01 = 2'b01,
    ENDS_10 = 2'b10,
    ENDS_11 = 2'b11
  } ends_kind_e;
endpackage

// File: rtl/pap_bounds.sv
module pap_bounds
  import prefix_ap_pkg::*;
#(
  parameter  int W  = 32,
  localparam int IW = $clog2(W),
  localparam int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  pfx,
  input  logic [LW-1:0] len,
  output logic [IW-1:0] lidx,
  output logic          lfound,
  output logic [IW-1:0] ridx,
  output logic          rfound
);
  logic [W-1:0] pos;  // pos[k] is the bit at prefix position k
  logic         first_b, last_b, l_tgt, r_tgt;
  ends_kind_e   kind;

  for (genvar k = 0; k < W; k++) begin : g_rev
    assign pos[k] = pfx[W-1-k];
  end

  always_comb begin
    first_b = pos[0];
    last_b  = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (k + 1 == int'(len)) last_b = pos[k];
    end
    kind = ends_kind_e'({first_b, last_b});
    unique case (kind)
      ENDS_00: begin l_tgt = 1'b1; r_tgt = 1'b1; end
      ENDS_01: begin l_tgt = 1'b1; r_tgt = 1'b0; end
      ENDS_10: begin l_tgt = 1'b0; r_tgt = 1'b1; end
      ENDS_11: begin l_tgt = 1'b0; r_tgt = 1'b0; end
    endcase

    // Leading boundary: smallest position that holds the target value.
    lfound = 1'b0;
    lidx   = '0;
    for (int k = W - 1; k >= 1; k--) begin
      if (k < int'(len) && pos[k] == l_tgt) begin
        lfound = 1'b1;
        lidx   = IW'(k);
      end
    end

    // Trailing boundary: largest position before the last bit with the target value.
    rfound = 1'b0;
    ridx   = '0;
    for (int k = 0; k < W - 1; k++) begin
      if (k < int'(len) - 1 && pos[k] == r_tgt) begin
        rfound = 1'b1;
        ridx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/pap_slice.sv
module pap_slice #(
  parameter  int W  = 32,
  localparam int IW = $clog2(W),
  localparam int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  pfx,
  input  logic [LW-1:0] len,
  input  logic [IW-1:0] lidx,
  input  logic          lfound,
  input  logic [IW-1:0] ridx,
  input  logic          rfound,
  output logic [LW-1:0] x_len,
  output logic [LW-1:0] z_len,
  output logic [W-1:0]  ap,
  output logic [LW-1:0] ap_len
);
  logic [W-1:0] shifted, keep;

  always_comb begin
    x_len   = '0;
    z_len   = '0;
    ap_len  = '0;
    ap      = '0;
    shifted = '0;
    keep    = '0;
    if (lfound && rfound && int'(ridx) > int'(lidx) + 1) begin
      x_len   = LW'(int'(lidx) + 1);
      z_len   = LW'(int'(len) - int'(ridx));
      ap_len  = LW'(int'(ridx) - int'(lidx) - 1);
      shifted = pfx << (int'(lidx) + 1);
      keep    = ~({W{1'b1}} >> ap_len);
      ap      = shifted & keep;
    end
  end
endmodule

// File: rtl/prefix_ap_extractor.sv
module prefix_ap_extractor #(
  parameter  int W  = 32,
  localparam int IW = $clog2(W),
  localparam int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_prefix,
  input  logic [LW-1:0] in_len,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_x_len,
  output logic [LW-1:0] out_z_len,
  output logic [W-1:0]  out_ap,
  output logic [LW-1:0] out_ap_len,
  output logic          out_conflict
);
  logic          adv;
  logic [LW-1:0] len_c;
  logic [W-1:0]  pfx_m;
  logic [IW-1:0] b_lidx, b_ridx;
  logic          b_lf, b_rf;

  // Stage 1 registers
  logic          s1_v;
  logic [W-1:0]  s1_pfx;
  logic [LW-1:0] s1_len;
  logic [IW-1:0] s1_lidx, s1_ridx;
  logic          s1_lf, s1_rf;

  // Slice results and conflict history
  logic [LW-1:0] sl_x, sl_z, sl_len;
  logic [W-1:0]  sl_ap;
  logic [W-1:0]  hist_ap;
  logic [LW-1:0] hist_len;
  logic          hist_ok;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  always_comb begin
    len_c = (int'(in_len) > W) ? LW'(W) : in_len;
    pfx_m = (len_c == '0) ? '0 : (in_prefix & ~({W{1'b1}} >> len_c));
  end

  pap_bounds #(.W(W)) u_bounds (
    .pfx(pfx_m), .len(len_c),
    .lidx(b_lidx), .lfound(b_lf), .ridx(b_ridx), .rfound(b_rf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_pfx  <= '0;
      s1_len  <= '0;
      s1_lidx <= '0;
      s1_ridx <= '0;
      s1_lf   <= 1'b0;
      s1_rf   <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_pfx  <= pfx_m;
        s1_len  <= len_c;
        s1_lidx <= b_lidx;
        s1_ridx <= b_ridx;
        s1_lf   <= b_lf;
        s1_rf   <= b_rf;
      end
    end
  end

  pap_slice #(.W(W)) u_slice (
    .pfx(s1_pfx), .len(s1_len),
    .lidx(s1_lidx), .lfound(s1_lf), .ridx(s1_ridx), .rfound(s1_rf),
    .x_len(sl_x), .z_len(sl_z), .ap(sl_ap), .ap_len(sl_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_x_len    <= '0;
      out_z_len    <= '0;
      out_ap       <= '0;
      out_ap_len   <= '0;
      out_conflict <= 1'b0;
      hist_ap      <= '0;
      hist_len     <= '0;
      hist_ok      <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_x_len    <= sl_x;
        out_z_len    <= sl_z;
        out_ap       <= sl_ap;
        out_ap_len   <= sl_len;
        out_conflict <= hist_ok && (sl_len != '0) && (sl_len == hist_len) && (sl_ap == hist_ap);
        hist_ap      <= sl_ap;
        hist_len     <= sl_len;
        hist_ok      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pap_checker.sv
module pap_checker #(
  parameter  int W  = 32,
  localparam int LW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] out_x_len,
  input logic [LW-1:0] out_z_len,
  input logic [W-1:0]  out_ap,
  input logic [LW-1:0] out_ap_len,
  input logic          out_conflict
);
  AST_EMPTY_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ap_len == '0 |-> out_ap == '0 && out_x_len == '0 && out_z_len == '0); // R5
  AST_AP_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ap_len != '0 |-> (out_ap & ({W{1'b1}} >> out_ap_len)) == '0); // R3
  AST_SPAN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ap_len != '0 |-> out_x_len >= 2 && out_z_len >= 2
      && int'(out_x_len) + int'(out_z_len) + int'(out_ap_len) <= W); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ap) && $stable(out_ap_len)
      && $stable(out_x_len) && $stable(out_z_len) && $stable(out_conflict)); // R8
  AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_CONFLICT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_conflict |-> out_ap_len != '0); // R6
  AST_TWO_EDGE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid); // R7
endmodule

bind prefix_ap_extractor pap_checker #(.W(W)) u_pap_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_x_len(out_x_len),
  .out_z_len(out_z_len), .out_ap(out_ap), .out_ap_len(out_ap_len),
  .out_conflict(out_conflict)
);

// File: tb/prefix_ap_extractor_test.sv
module prefix_ap_extractor_test;
  localparam int W  = 32;
  localparam int LW = $clog2(W + 1);
  localparam int N  = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_prefix = '0;
  logic [LW-1:0] in_len = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [LW-1:0] out_x_len, out_z_len, out_ap_len;
  logic [W-1:0]  out_ap;
  logic          out_conflict;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prefix_ap_extractor #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_prefix(in_prefix), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_x_len(out_x_len), .out_z_len(out_z_len),
    .out_ap(out_ap), .out_ap_len(out_ap_len), .out_conflict(out_conflict)
  );

  // Vectors: prefix, length, expected x, z, active bits (right-aligned), active length, conflict
  localparam logic [31:0] T_PFX [N] = '{
    32'h6C000000, 32'h2C000000, 32'h64000000, 32'h34000000, 32'h35000000,
    32'hD2000000, 32'hC9C00000, 32'hF0000000, 32'h60000000, 32'h40000000,
    32'hFFFFFFFF, 32'h40000002, 32'h6FFFFFFF, 32'h6D555555, 32'h40000002};
  localparam int T_LEN  [N] = '{6, 8, 6, 7, 8, 8, 10, 4, 4, 2, 0, 32, 6, 6, 40};
  localparam int T_X    [N] = '{2, 3, 2, 3, 3, 3, 3, 0, 0, 0, 0, 2, 2, 2, 2};
  localparam int T_Z    [N] = '{3, 3, 2, 2, 2, 2, 4, 0, 0, 0, 0, 2, 3, 3, 2};
  localparam int T_APV  [N] = '{1, 1, 2, 2, 5, 4, 2, 0, 0, 0, 0, 0, 1, 1, 0};
  localparam int T_APL  [N] = '{1, 2, 2, 2, 3, 3, 3, 0, 0, 0, 0, 28, 1, 1, 28};
  localparam int T_CF   [N] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam string T_REQ [N] = '{"R1", "R3", "R2", "R6", "R2", "R1", "R3", "R5",
                                  "R5", "R5", "R5", "R3", "R4", "R4", "R4"};

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [W-1:0] align(input int v, input int l);
    if (l == 0) return '0;
    return W'(v) << (W - l);
  endfunction

  task automatic check_out(input string req, input int idx);
    chk(req, "out_valid", out_valid, 1);
    chk(req, "x_len", out_x_len, T_X[idx]);
    chk(req, "z_len", out_z_len, T_Z[idx]);
    chk(req, "ap", out_ap, align(T_APV[idx], T_APL[idx]));
    chk(req, "ap_len", out_ap_len, T_APL[idx]);
  endtask

  task automatic drive(input int idx);
    in_valid  = 1'b1;
    in_prefix = T_PFX[idx];
    in_len    = LW'(T_LEN[idx]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R9", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "in_ready after reset", in_ready, 1);
    chk("R9", "out_valid after reset", out_valid, 0);

    // Table walk: one prefix at a time, result two edges later
    for (int i = 0; i < N; i++) begin
      drive(i);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check_out(T_REQ[i], i);
      chk("R6", "conflict", out_conflict, T_CF[i]);
    end
    @(negedge clk);
    chk("R7", "valid drops", out_valid, 0);

    // Back-to-back stream of three prefixes
    drive(4);
    @(negedge clk);
    drive(5);
    @(negedge clk);
    drive(6);
    chk("R7", "stream in_ready", in_ready, 1);
    check_out("R7", 4);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R7", 5);
    @(negedge clk);
    check_out("R7", 6);
    @(negedge clk);

    // Stall with data held at the output
    out_ready = 1'b0;
    drive(4);
    @(negedge clk);
    drive(5);
    @(negedge clk);
    drive(6);
    for (int k = 0; k < 3; k++) begin
      chk("R8", "in_ready stalled", in_ready, 0);
      check_out("R8", 4);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R8", 5);
    @(negedge clk);
    check_out("R8", 6);
    @(negedge clk);
    chk("R8", "drained", out_valid, 0);

    // Reset clears the conflict history
    drive(0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "valid cleared", out_valid, 0);
    rst_n = 1'b1;
    drive(0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_out("R9", 0);
    chk("R9", "first conflict after reset", out_conflict, 0);
    drive(0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R6", "repeat conflict", out_conflict, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule